// File: doc/BRIEF.md
# Adjacent Sample Pair Scan Sequencer

This block walks cyclically through a table of sixteen signed level words, one per slider, and on every scan step hands one adjacent pair of words to a downstream slope generator: the lower-numbered entry as the segment start value and the next entry as the segment end value. One full pass produces sixteen segments, 0→1, 1→2, … 14→15 and finally 15→0, after which the sequence repeats, so the resulting waveform is periodic.

Selection is split over two narrow select registers. One drives a selector over the even entries (entry 2·A), the other drives a selector over the odd entries (entry 2·B+1). Accepted steps alternate between incrementing A and copying A into B, so every step replaces only one endpoint and keeps the other. A lead bit, toggled on every step, swaps the two selector outputs so the earlier entry always reaches the start output. Everything runs on one clock; a step-enable tick marks when the scan advances.

Top module: `pair_scan_seq`

## Requirements
- R1: While reset is held and right after it, seg_idx_o is 0, seg_start_o is 0, and the presented pair is entry 0 → entry 1.
- R2: start_o equals entry seg_idx_o and end_o equals entry (seg_idx_o+1) mod 16, where entry k occupies samples_i[k*W +: W].
- R3: Each step_en sampled high advances seg_idx_o by exactly one, including steps on consecutive cycles.
- R4: After segment 15 the next step gives segment 0 with the pair 15 → 0, then 0 → 1 again, so the sequence has period 16.
- R5: With step_en low, seg_idx_o holds and seg_start_o stays low.
- R6: seg_start_o is high in the cycle in which the new pair first appears on the outputs, which is two clock edges after the edge that samples step_en high.
- R7: start_o and end_o are registered and follow a change of the selected sample inputs one clock edge later, with no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Scan step tick, one step per cycle in which it is high |
| samples_i | input | N*W | Sixteen signed level words, entry k at bits k*W +: W |
| start_o | output | W | Segment start level (earlier entry of the pair) |
| end_o | output | W | Segment end level (later entry of the pair) |
| seg_idx_o | output | 4 | Number of the start entry of the current pair |
| seg_start_o | output | 1 | One-cycle pulse when a new pair becomes valid |

## Verification
Isolated steps with random idle gaps show that the index moves only on a tick and that the strobe lands in the right cycle; a burst of back-to-back ticks separates a design that needs idle cycles between steps from one that does not. Runs of more than sixteen steps cross the wrap from 15 to 0 several times, exposing a wrong pair order or a lost endpoint at the seam. Random sample values, distinct per entry, make any swap of start and end or any off-by-one entry visible, and changing samples without a step shows that the outputs track live inputs.

// File: rtl/pair_scan_pkg.sv
package pair_scan_pkg;
  // Which bank currently holds the earlier entry of the pair
  typedef enum logic {
    LEAD_EVEN = 1'b0,
    LEAD_ODD  = 1'b1
  } lead_e;
endpackage

// File: rtl/pair_scan_ctrl.sv
module pair_scan_ctrl
  import pair_scan_pkg::*;
#(
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  output logic [SELW-1:0] sel_a,
  output logic [SELW-1:0] sel_b,
  output lead_e           lead
);

  logic [SELW-1:0] sel_a_d, sel_b_d;
  lead_e           lead_d;

  // Next state: alternate between bumping A and copying A into B
  always_comb begin
    sel_a_d = sel_a;
    sel_b_d = sel_b;
    lead_d  = lead;
    if (step_en) begin
      if (lead == LEAD_EVEN) begin
        sel_a_d = sel_a + 1'b1;
        lead_d  = LEAD_ODD;
      end else begin
        sel_b_d = sel_a;
        lead_d  = LEAD_EVEN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a <= '0;
      sel_b <= '0;
      lead  <= LEAD_EVEN;
    end else begin
      sel_a <= sel_a_d;
      sel_b <= sel_b_d;
      lead  <= lead_d;
    end
  end

endmodule

// File: rtl/pair_scan_bank.sv
module pair_scan_bank #(
  parameter int W    = 12,
  parameter int N    = 16,
  parameter bit ODD  = 1'b0,
  localparam int HALF = N / 2,
  localparam int SELW = $clog2(HALF)
) (
  input  logic [N*W-1:0]      samples_i,
  input  logic [SELW-1:0]     sel,
  output logic signed [W-1:0] word
);

  logic signed [W-1:0] half_words [HALF];

  // Keep only the entries of this bank's parity
  for (genvar g = 0; g < HALF; g++) begin : g_pick
    assign half_words[g] = samples_i[(2*g + int'(ODD))*W +: W];
  end

  assign word = half_words[sel];

endmodule

// File: rtl/pair_scan_seq.sv
module pair_scan_seq
  import pair_scan_pkg::*;
#(
  parameter int W = 12,
  parameter int N = 16,
  localparam int HALF = N / 2,
  localparam int SELW = $clog2(HALF),
  localparam int IDXW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic [N*W-1:0]      samples_i,
  output logic signed [W-1:0] start_o,
  output logic signed [W-1:0] end_o,
  output logic [IDXW-1:0]     seg_idx_o,
  output logic                seg_start_o
);

  logic [SELW-1:0]     sel_a, sel_b;
  lead_e               lead;
  logic signed [W-1:0] bank_word [2];
  logic [SELW-1:0]     bank_sel  [2];
  logic signed [W-1:0] start_d, end_d;
  logic [IDXW-1:0]     idx_d;
  logic                step_q;

  pair_scan_ctrl #(.SELW(SELW)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(step_en),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .lead   (lead)
  );

  assign bank_sel[0] = sel_a;
  assign bank_sel[1] = sel_b;

  // Bank 0 covers even entries, bank 1 odd entries
  for (genvar b = 0; b < 2; b++) begin : g_bank
    pair_scan_bank #(.W(W), .N(N), .ODD(b[0])) i_bank (
      .samples_i(samples_i),
      .sel      (bank_sel[b]),
      .word     (bank_word[b])
    );
  end

  // Swap stage: earlier entry to start, later entry to end
  always_comb begin
    if (lead == LEAD_EVEN) begin
      start_d = bank_word[0];
      end_d   = bank_word[1];
      idx_d   = {sel_a, 1'b0};
    end else begin
      start_d = bank_word[1];
      end_d   = bank_word[0];
      idx_d   = {sel_b, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o     <= '0;
      end_o       <= '0;
      seg_idx_o   <= '0;
      step_q      <= 1'b0;
      seg_start_o <= 1'b0;
    end else begin
      start_o     <= start_d;
      end_o       <= end_d;
      seg_idx_o   <= idx_d;
      step_q      <= step_en;
      seg_start_o <= step_q;
    end
  end

endmodule

// File: rtl/pair_scan_chk.sv
module pair_scan_chk #(
  parameter int W = 12,
  parameter int N = 16,
  localparam int IDXW = $clog2(N)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_en,
  input logic [N*W-1:0]      samples_i,
  input logic signed [W-1:0] start_o,
  input logic signed [W-1:0] end_o,
  input logic [IDXW-1:0]     seg_idx_o,
  input logic                seg_start_o
);

  logic            seen;
  logic [IDXW-1:0] nxt_idx;
  logic [IDXW-1:0] inc_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assign nxt_idx = IDXW'(seg_idx_o + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inc_idx <= IDXW'(1);
    else        inc_idx <= nxt_idx;
  end

  AST_RESET_IDX: assert property (@(posedge clk) !rst_n |-> seg_idx_o == '0 && !seg_start_o); // R1

  AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $stable(samples_i)) |->
      (start_o == $signed(samples_i[seg_idx_o*W +: W]) &&
       end_o   == $signed(samples_i[nxt_idx*W +: W]))); // R2

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && seg_start_o) |-> seg_idx_o == inc_idx); // R3

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !seg_start_o) |-> $stable(seg_idx_o)); // R5

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_start_o |-> $past(step_en, 2)); // R6

endmodule

bind pair_scan_seq pair_scan_chk #(.W(W), .N(N)) i_chk (.*);

// File: tb/test_pair_scan_seq.sv
module test_pair_scan_seq;
  localparam int W = 12;
  localparam int N = 16;

  logic                clk;
  logic                rst_n;
  logic                step_en;
  logic [N*W-1:0]      samples_i;
  logic signed [W-1:0] start_o, end_o;
  logic [3:0]          seg_idx_o;
  logic                seg_start_o;

  logic signed [W-1:0] samp [N];
  int checks, fails, exp_idx;
  bit done;

  pair_scan_seq #(.W(W), .N(N)) i_pair_scan_seq (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .samples_i(samples_i),
    .start_o(start_o), .end_o(end_o), .seg_idx_o(seg_idx_o), .seg_start_o(seg_start_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic pack();
    for (int k = 0; k < N; k++) samples_i[k*W +: W] = samp[k];
  endtask

  task automatic randomize_samples();
    for (int k = 0; k < N; k++) samp[k] = W'($urandom);
    pack();
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pair(string req);
    chk({req, " idx"},   int'(seg_idx_o), exp_idx);
    chk({req, " start"}, int'(start_o), int'(samp[exp_idx]));
    chk({req, " end"},   int'(end_o),   int'(samp[(exp_idx + 1) % N]));
  endtask

  // One isolated step: tick, then new pair two edges later
  task automatic one_step(string req);
    @(negedge clk) step_en = 1'b1;
    @(negedge clk) step_en = 1'b0;
    chk({req, " R6 no early strobe"}, int'(seg_start_o), 0);
    @(negedge clk);
    exp_idx = (exp_idx + 1) % N;
    chk({req, " R6 strobe"}, int'(seg_start_o), 1);
    chk_pair({req, " R2 R3"});
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    checks = 0; fails = 0; exp_idx = 0; done = 0;
    rst_n = 1'b0; step_en = 1'b0;
    randomize_samples();
    repeat (3) @(negedge clk);
    chk("R1 idx in reset", int'(seg_idx_o), 0);
    chk("R1 strobe in reset", int'(seg_start_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pair("R1 first pair");
    chk("R1 strobe after reset", int'(seg_start_o), 0);

    // Isolated steps with random idle gaps, crossing the wrap (R4)
    for (int s = 0; s < 40; s++) begin
      one_step(exp_idx == 15 ? "R4 wrap" : "R3 step");
      for (int g = 0; g < int'($urandom_range(0, 3)); g++) begin
        @(negedge clk);
        chk("R5 idle strobe", int'(seg_start_o), 0);
        chk("R5 idle idx", int'(seg_idx_o), exp_idx);
      end
    end

    // Directed: bring index to 14 and cross 15 -> 0 -> 1
    while (exp_idx != 14) one_step("R3 align");
    one_step("R4 to 15");
    one_step("R4 pair 15->0");
    one_step("R4 back to 0->1");

    // R7: new sample values without a step
    randomize_samples();
    @(negedge clk);
    chk_pair("R7 track");
    chk("R7 no strobe", int'(seg_start_o), 0);

    // Back-to-back burst of 5 ticks (R3)
    begin
      int base;
      base = exp_idx;
      @(negedge clk) step_en = 1'b1;
      for (int j = 1; j <= 5; j++) begin
        @(negedge clk);
        if (j == 5) step_en = 1'b0;
        if (j >= 2) begin
          exp_idx = (base + j - 1) % N;
          chk("R3 burst strobe", int'(seg_start_o), 1);
          chk_pair("R3 burst");
        end
      end
      @(negedge clk);
      exp_idx = (base + 5) % N;
      chk("R3 burst last strobe", int'(seg_start_o), 1);
      chk_pair("R3 burst last");
      @(negedge clk);
      chk("R5 after burst", int'(seg_start_o), 0);
      chk("R5 after burst idx", int'(seg_idx_o), exp_idx);
    end

    // Random sample refresh between steps
    for (int s = 0; s < 20; s++) begin
      randomize_samples();
      one_step("R2 random");
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule